// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline. It holds the fetch program counter and the fetch/decode pipeline register. It decodes the instruction in decode and exposes that instruction's source register index. The register value comes back on `rs_val_i`, already forwarded by logic outside the block. The branch condition is a single zero test on that value. A dedicated adder forms the target from the sequential address and the scaled displacement. Because of this, a redirected fetch costs one cycle rather than the three it would cost if the branch were settled in the memory stage.

A two-bit policy input selects how the pipeline treats the instruction fetched behind a branch. Under the stall policy, that instruction is always discarded. Under predict-not-taken, it is discarded only when the branch turns out taken. Under the delayed policy, it always runs as a delay slot. A discarded instruction is replaced in decode by an invalid all-zero no-op. The policy is meant to stay fixed between resets.

Top module: `erb_unit`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, the fetch PC equals `RESET_PC` (default 0). `id_valid_o` is 0, and both `br_taken_o` and `flush_o` are 0.
- R2: Instruction fields sit at fixed positions: opcode in bits 31:26, source register in 25:21 (driven on `rs_idx_o`), and displacement in 15:0. Opcode 6'h04 branches when the source value is zero, and opcode 6'h05 branches when it is nonzero. Any other opcode is never taken and never flushes.
- R3: For opcode 6'h04, `br_taken_o` is 1 exactly when all bits of `rs_val_i` are zero. For opcode 6'h05, it is 1 when any bit is set, including only the top bit.
- R4: The target is the branch's own address plus 4, plus the sign-extended 16-bit displacement shifted left by two, computed modulo 2^32. Both extreme displacements, 16'h7FFF and 16'h8000, are included.
- R5: With policy 2'd0 (stall) or 2'd3 (treated as stall), every valid branch in decode raises `flush_o`. `next_pc_o` is then the target if the branch is taken, or the branch's address plus 4 if it is not, so that address is fetched again.
- R6: With policy 2'd1 (predict not taken), a branch that is not taken leaves `flush_o` low, and fetch goes on at fetch PC + 4. A taken branch raises `flush_o` and redirects fetch to the target.
- R7: With policy 2'd2 (delayed), `flush_o` is never raised. The instruction behind a branch enters decode as valid, and a taken branch sends the following fetch to the target.
- R8: After a cycle with `flush_o` high, decode holds the no-op: `id_valid_o` is 0 and `id_instr_o` is 0.
- R9: The redirected PC appears on `fetch_pc_o` at the clock edge that ends the branch's decode cycle. Fetch then goes on sequentially from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 2 | 0 stall, 1 predict-not-taken, 2 delayed, 3 stall |
| imem_rdata_i | input | 32 | Instruction read at `fetch_pc_o` |
| rs_val_i | input | XLEN | Forwarded value of register `rs_idx_o` |
| fetch_pc_o | output | XLEN | Current fetch address |
| id_instr_o | output | 32 | Instruction held in decode |
| id_valid_o | output | 1 | Decode entry is a real instruction |
| rs_idx_o | output | 5 | Source register field of the decode entry |
| br_taken_o | output | 1 | Branch in decode is taken |
| next_pc_o | output | XLEN | Fetch address for the next cycle |
| flush_o | output | 1 | Discard the instruction now being fetched |

## Verification
The hardest situation to reach from the ports is the state around a decoded branch. There, the redirect and the discard of the instruction behind the branch must line up in the same edge. The delay-slot instruction must survive under one policy and be removed under the others. To get there, the bench models instruction memory from `fetch_pc_o` and places one branch at address 4. It releases reset so that the branch reaches decode exactly two edges later, then observes the decode cycle and the one or two cycles after it. Displacements of both signs, the extreme values, and a value whose only set bit is the top one probe the adder and the zero test.

// File: rtl/erb_pkg.sv
// Shared definitions for the decode-stage branch resolver.
// Assumes 32-bit instructions with the opcode in 31:26.
package erb_pkg;
    typedef enum logic [1:0] {
        POL_STALL  = 2'd0,
        POL_PNT    = 2'd1,
        POL_DELAY  = 2'd2,
        POL_STALL2 = 2'd3
    } policy_e;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned OP_W    = 6;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned DISP_W  = 16;

    localparam logic [OP_W-1:0] OP_BR_ZERO    = 6'h04;
    localparam logic [OP_W-1:0] OP_BR_NONZERO = 6'h05;
endpackage

// File: rtl/erb_cond.sv
// Zero test and branch decode for the instruction in decode.
// Assumes rs_val_i is already forwarded for this instruction.
module erb_cond
    import erb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [XLEN-1:0] rs_val_i,
    output logic            is_branch_o,
    output logic            taken_o
);
    logic is_zero;

    // Decide whether the entry is a branch and whether its condition holds.
    always_comb begin
        is_zero     = (rs_val_i == '0);
        is_branch_o = valid_i && ((op_i == OP_BR_ZERO) || (op_i == OP_BR_NONZERO));
        taken_o     = is_branch_o && ((op_i == OP_BR_ZERO) ? is_zero : !is_zero);
    end
endmodule

// File: rtl/erb_target.sv
// Dedicated target adder: sequential PC plus scaled, sign-extended displacement.
// Assumes XLEN is at least DISP_W + 2.
module erb_target
    import erb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0]   pc_plus4_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [XLEN-1:0]   target_o
);
    localparam int unsigned EXT_W = XLEN - DISP_W - 2;

    logic [XLEN-1:0] offset;

    // Sign extend, scale by four and add.
    always_comb begin
        offset   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
        target_o = pc_plus4_i + offset;
    end
endmodule

// File: rtl/erb_policy.sv
// Selects the next fetch address and the discard request for the chosen policy.
// Assumes branch_i/taken_i describe the instruction currently in decode.
module erb_policy
    import erb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  policy_e         policy_i,
    input  logic            branch_i,
    input  logic            taken_i,
    input  logic [XLEN-1:0] target_i,
    input  logic [XLEN-1:0] seq_pc_i,
    input  logic [XLEN-1:0] fetch_next_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            flush_o
);
    // Apply the stall, predict-not-taken or delay-slot rule.
    always_comb begin
        next_pc_o = fetch_next_i;
        flush_o   = 1'b0;
        if (branch_i) begin
            case (policy_i)
                POL_PNT: begin
                    if (taken_i) begin
                        next_pc_o = target_i;
                        flush_o   = 1'b1;
                    end
                end
                POL_DELAY: begin
                    if (taken_i) begin
                        next_pc_o = target_i;
                    end
                end
                default: begin
                    next_pc_o = taken_i ? target_i : seq_pc_i;
                    flush_o   = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/erb_unit.sv
// Decode-stage branch resolver: fetch PC register, fetch/decode register,
// zero test, target adder and policy select. Assumes policy_i is stable
// between resets and imem_rdata_i is the word at fetch_pc_o in the same cycle.
module erb_unit
    import erb_pkg::*;
#(
    parameter int unsigned     XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         policy_i,
    input  logic [INSTR_W-1:0] imem_rdata_i,
    input  logic [XLEN-1:0]    rs_val_i,
    output logic [XLEN-1:0]    fetch_pc_o,
    output logic [INSTR_W-1:0] id_instr_o,
    output logic               id_valid_o,
    output logic [REG_W-1:0]   rs_idx_o,
    output logic               br_taken_o,
    output logic [XLEN-1:0]    next_pc_o,
    output logic               flush_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0]    fetch_pc_q;
    logic [XLEN-1:0]    id_pc4_q;
    logic [INSTR_W-1:0] id_instr_q;
    logic               id_valid_q;
    logic               is_branch;
    logic [XLEN-1:0]    target;
    logic [XLEN-1:0]    fetch_pc4;

    assign fetch_pc4 = fetch_pc_q + STEP;

    erb_cond #(.XLEN(XLEN)) u_cond (
        .valid_i     (id_valid_q),
        .op_i        (id_instr_q[31:26]),
        .rs_val_i    (rs_val_i),
        .is_branch_o (is_branch),
        .taken_o     (br_taken_o)
    );

    erb_target #(.XLEN(XLEN)) u_target (
        .pc_plus4_i (id_pc4_q),
        .disp_i     (id_instr_q[15:0]),
        .target_o   (target)
    );

    erb_policy #(.XLEN(XLEN)) u_policy (
        .policy_i     (policy_e'(policy_i)),
        .branch_i     (is_branch),
        .taken_i      (br_taken_o),
        .target_i     (target),
        .seq_pc_i     (id_pc4_q),
        .fetch_next_i (fetch_pc4),
        .next_pc_o    (next_pc_o),
        .flush_o      (flush_o)
    );

    // Advance fetch and load decode, replacing a discarded fetch with a no-op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc_q <= RESET_PC;
            id_pc4_q   <= RESET_PC;
            id_instr_q <= '0;
            id_valid_q <= 1'b0;
        end else begin
            fetch_pc_q <= next_pc_o;
            id_pc4_q   <= fetch_pc4;
            if (flush_o) begin
                id_instr_q <= '0;
                id_valid_q <= 1'b0;
            end else begin
                id_instr_q <= imem_rdata_i;
                id_valid_q <= 1'b1;
            end
        end
    end

    assign fetch_pc_o = fetch_pc_q;
    assign id_instr_o = id_instr_q;
    assign id_valid_o = id_valid_q;
    assign rs_idx_o   = id_instr_q[25:21];
endmodule

// File: rtl/erb_unit_chk.sv
// Property checker for erb_unit, attached with bind below.
module erb_unit_chk
    import erb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         policy_i,
    input logic [XLEN-1:0]    rs_val_i,
    input logic [XLEN-1:0]    fetch_pc_o,
    input logic [INSTR_W-1:0] id_instr_o,
    input logic               id_valid_o,
    input logic               br_taken_o,
    input logic               flush_o
);
    logic is_br;
    assign is_br = id_valid_o && ((id_instr_o[31:26] == OP_BR_ZERO) || (id_instr_o[31:26] == OP_BR_NONZERO));

    AST_TAKEN_COND: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_o |-> (is_br && ((id_instr_o[31:26] == OP_BR_ZERO) == (rs_val_i == '0)))); // R3

    AST_FLUSH_ONLY_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> is_br); // R2

    AST_STALL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && (policy_i == 2'd0 || policy_i == 2'd3)) |-> flush_o); // R5

    AST_PNT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd1 && !flush_o) |=> fetch_pc_o == $past(fetch_pc_o) + XLEN'(4)); // R6

    AST_DELAY_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd2) |-> !flush_o); // R7

    AST_SQUASH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (!id_valid_o && id_instr_o == '0)); // R8
endmodule

bind erb_unit erb_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .policy_i   (policy_i),
    .rs_val_i   (rs_val_i),
    .fetch_pc_o (fetch_pc_o),
    .id_instr_o (id_instr_o),
    .id_valid_o (id_valid_o),
    .br_taken_o (br_taken_o),
    .flush_o    (flush_o)
);

// File: tb/erb_unit_bench.sv
// Bench for erb_unit: vector table of single branches at address 4, then directed tests.
module erb_unit_bench;
    localparam int XLEN = 32;

    typedef struct packed {
        logic [1:0]  pol;
        logic [5:0]  op;
        logic [31:0] rs;
        logic [15:0] disp;
        logic        taken;
        logic        flush;
        logic [31:0] npc;
    } vec_t;

    // Branch sits at 0x04, so decode holds it while fetch is at 0x08; target base is 0x08.
    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 6'h04, 32'h0,        16'h0003, 1'b1, 1'b1, 32'h0000_0014}, // R5 taken
        '{2'd0, 6'h04, 32'h5,        16'h0003, 1'b0, 1'b1, 32'h0000_0008}, // R5 refetch
        '{2'd1, 6'h04, 32'h0,        16'h0003, 1'b1, 1'b1, 32'h0000_0014}, // R6 taken
        '{2'd1, 6'h04, 32'h5,        16'h0003, 1'b0, 1'b0, 32'h0000_000C}, // R6 not taken
        '{2'd2, 6'h05, 32'h5,        16'h0003, 1'b1, 1'b0, 32'h0000_0014}, // R7 taken
        '{2'd2, 6'h05, 32'h0,        16'h0003, 1'b0, 1'b0, 32'h0000_000C}, // R7 not taken
        '{2'd1, 6'h05, 32'h1,        16'hFFFE, 1'b1, 1'b1, 32'h0000_0000}, // R4 backward
        '{2'd3, 6'h05, 32'h8000_0000,16'h0003, 1'b1, 1'b1, 32'h0000_0014}, // R3 top bit, R5 policy 3
        '{2'd0, 6'h23, 32'h0,        16'h0003, 1'b0, 1'b0, 32'h0000_000C}, // R2 non-branch
        '{2'd1, 6'h05, 32'h7,        16'h7FFF, 1'b1, 1'b1, 32'h0002_0004}, // R4 max forward
        '{2'd2, 6'h04, 32'h0,        16'h8000, 1'b1, 1'b0, 32'hFFFE_0008}  // R4 max backward
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      policy = 2'd0;
    logic [XLEN-1:0] rs_val = '0;
    logic [31:0]     mem [16];
    logic [31:0]     imem_rdata;
    logic [XLEN-1:0] fetch_pc;
    logic [31:0]     id_instr;
    logic            id_valid;
    logic [4:0]      rs_idx;
    logic            br_taken;
    logic [XLEN-1:0] next_pc;
    logic            flush;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    assign imem_rdata = mem[fetch_pc[5:2]];

    erb_unit u_erb_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .policy_i     (policy),
        .imem_rdata_i (imem_rdata),
        .rs_val_i     (rs_val),
        .fetch_pc_o   (fetch_pc),
        .id_instr_o   (id_instr),
        .id_valid_o   (id_valid),
        .rs_idx_o     (rs_idx),
        .br_taken_o   (br_taken),
        .next_pc_o    (next_pc),
        .flush_o      (flush)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Load a branch at 0x04, reset, and stop at the negedge of its decode cycle.
    task automatic to_decode(input logic [1:0] pol, input logic [31:0] word, input logic [31:0] rs);
        mem[1] = word;
        policy = pol;
        rs_val = rs;
        rst_n  = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] br_word(input logic [5:0] op, input logic [15:0] d);
        return {op, 5'd1, 5'd0, d};
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0000_0100 | i;

        // R1: reset state
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 fetch_pc in reset", fetch_pc, 32'h0);
        rst_n = 1'b1;
        check("R1 fetch_pc after release", fetch_pc, 32'h0);
        check("R1 id_valid", {31'd0, id_valid}, 32'd0);
        check("R1 flush", {31'd0, flush}, 32'd0);
        check("R1 taken", {31'd0, br_taken}, 32'd0);

        // Vector table: one branch per run
        for (int v = 0; v < NV; v++) begin
            to_decode(VEC[v].pol, br_word(VEC[v].op, VEC[v].disp), VEC[v].rs);
            check($sformatf("R2 rs_idx v%0d", v), {27'd0, rs_idx}, 32'd1);
            check($sformatf("R3 taken v%0d", v), {31'd0, br_taken}, {31'd0, VEC[v].taken});
            check($sformatf("R5/R6/R7 flush v%0d", v), {31'd0, flush}, {31'd0, VEC[v].flush});
            check($sformatf("R4 next_pc v%0d", v), next_pc, VEC[v].npc);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R9 fetch_pc v%0d", v), fetch_pc, VEC[v].npc);
            check($sformatf("R8 id_valid v%0d", v), {31'd0, id_valid}, {31'd0, ~VEC[v].flush});
        end

        // R5/R8: stall, not taken: bubble, then the successor at 0x08 is refetched
        to_decode(2'd0, br_word(6'h04, 16'h0003), 32'h9);
        @(posedge clk);
        @(negedge clk);
        check("R8 stall bubble instr", id_instr, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R5 refetched successor", id_instr, mem[2]);
        check("R5 fetch after refetch", fetch_pc, 32'h0000_000C);

        // R7/R9: delayed, taken: delay slot valid, then target instruction
        to_decode(2'd2, br_word(6'h04, 16'h0003), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R7 delay slot valid", {31'd0, id_valid}, 32'd1);
        check("R7 delay slot instr", id_instr, mem[2]);
        @(posedge clk);
        @(negedge clk);
        check("R9 target instr", id_instr, mem[5]);
        check("R9 sequential after target", fetch_pc, 32'h0000_0018);

        // R6/R8: predict-not-taken, taken: squashed slot, then target
        to_decode(2'd1, br_word(6'h05, 16'h0003), 32'h3);
        @(posedge clk);
        @(negedge clk);
        check("R8 squashed instr", id_instr, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R6 target instr", id_instr, mem[5]);
        check("R9 fetch after squash", fetch_pc, 32'h0000_0018);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cycles > 5000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule